// File: doc/BRIEF.md
# Programmable Periodic Rate Divider

This block is the divider chain of a real-time clock. It counts cycles of a 32.768 kHz time base in a 15-bit counter. A four-bit rate code picks one counter bit, called the tap. The tap can be driven out as a square wave, and each rising edge of the tap gives a one-cycle strobe. The most significant bit of the counter gives the once-per-second update tick. The tick is preceded by a short busy window, which tells software that the time registers are about to change. A three-bit oscillator code starts the chain, stops it, or holds it cleared.

A small sequencer has four states. CHAIN_STOP means the oscillator is off. CHAIN_HOLD means the oscillator runs but the chain is held cleared. CHAIN_COUNT means the chain counts normally. CHAIN_WARN is the busy window just before a tick. The transitions are:
- Any state goes to CHAIN_HOLD on codes 110 and 111, and to CHAIN_STOP on every other code except 010.
- CHAIN_STOP or CHAIN_HOLD goes to CHAIN_COUNT on code 010.
- CHAIN_COUNT goes to CHAIN_WARN when the count reaches 16375 and the hold-off input is low.
- CHAIN_WARN goes back to CHAIN_COUNT on the tick cycle, or at once when the hold-off input is raised.

Running cycle 0 is the cycle that follows the first clock edge at which `osc_ctl` = 010 is sampled. In running cycle n the chain count equals n modulo 32768.

Top module: `rtc_rate_divider`

## Requirements
- R1: Only `osc_ctl` = 010 lets the chain count. Each entry into counting restarts the count from zero.
- R2: From the cycle after any other `osc_ctl` code is sampled (codes 11x hold the chain, the remaining codes stop it), `sq_wave`, `rate_edge`, `sec_tick` and `upd_busy` all stay low.
- R3: `sec_tick` is high for exactly one cycle, first in running cycle 16384, and then every 32768 cycles after that.
- R4: Rate code mapping. Code 0 disables the tap, so there is no square wave and no strobe. Code 1 gives a period of 128 cycles and code 2 a period of 256 cycles. A code c from 3 to 15 gives a period of 2^(c-1) cycles. The tap is high in the second half of each period.
- R5: `sq_wave` follows the tap while `sq_enable` = 1. It is low while `sq_enable` = 0, and low while `rst_n` = 0.
- R6: `rate_edge` is a one-cycle pulse at each rising edge of the tap, whatever the value of `sq_enable`. The first pulse comes half a period into counting.
- R7: `upd_busy` is high in running cycles 16376 to 16384 (the eight cycles before the tick plus the tick cycle itself), repeats every 32768 cycles, and is low at all other times.
- R8: While `set_mode` = 1, `upd_busy` and `sec_tick` are held low in the same cycle. The chain and the rate strobes keep running.
- R9: `rst_n` changes only `sq_wave`. The chain count, the tick schedule and `upd_busy` are not affected by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tb_clk | input | 1 | 32.768 kHz time-base clock |
| rst_n | input | 1 | Active-low reset; forces the square wave low |
| rate_sel | input | 4 | Rate code that selects the tap |
| osc_ctl | input | 3 | Oscillator and chain control code |
| sq_enable | input | 1 | Drives the tap onto `sq_wave` |
| set_mode | input | 1 | Hold-off that suppresses updates and clears busy |
| sq_wave | output | 1 | Square-wave output |
| rate_edge | output | 1 | One-cycle strobe on each rising tap edge |
| sec_tick | output | 1 | One-cycle update tick at 1 Hz |
| upd_busy | output | 1 | Warning window ahead of each update |

## Verification
The square-wave assertion assumes that `rate_sel` and `sq_enable` do not change across the edge it looks at. Without that, a change of code could raise the output with no tap edge behind it. The stimulus therefore changes the rate code only while the chain is stopped, and it drives every input on the falling clock edge. The busy-window assertion counts busy cycles from reset release, and the bench pulses reset only far away from any update window.

// File: rtl/rtcdiv_pkg.sv
package rtcdiv_pkg;

    // Width of a tap index into the chain counter
    localparam int TAP_W = 4;

    // Oscillator code that lets the chain count
    localparam logic [2:0] OSC_RUN = 3'b010;

    // Taps used by the two slow rate codes, and the offset for fast codes
    localparam logic [TAP_W-1:0] SLOW_A_TAP = 4'd6;
    localparam logic [TAP_W-1:0] SLOW_B_TAP = 4'd7;
    localparam logic [3:0]       FAST_OFS   = 4'd2;

    typedef enum logic [1:0] {
        CHAIN_STOP  = 2'd0,
        CHAIN_HOLD  = 2'd1,
        CHAIN_COUNT = 2'd2,
        CHAIN_WARN  = 2'd3
    } chain_state_e;

    // Map a rate code to the counter bit that forms the tap
    function automatic logic [TAP_W-1:0] tap_index(input logic [3:0] code);
        case (code)
            4'd0:    return '0;
            4'd1:    return SLOW_A_TAP;
            4'd2:    return SLOW_B_TAP;
            default: return TAP_W'(code - FAST_OFS);
        endcase
    endfunction

endpackage

// File: rtl/rtcdiv_chain.sv
module rtcdiv_chain #(
    parameter int CW = 15
) (
    input  logic          clk,
    input  logic          run,
    output logic [CW-1:0] count
);

    // The counter clears whenever the sequencer is not counting
    always_ff @(posedge clk) begin
        if (!run) count <= '0;
        else      count <= count + CW'(1);
    end

endmodule

// File: rtl/rtcdiv_seq.sv
module rtcdiv_seq
    import rtcdiv_pkg::*;
#(
    parameter int CW   = 15,
    parameter int LEAD = 8
) (
    input  logic          clk,
    input  logic [2:0]    osc_ctl,
    input  logic          set_mode,
    input  logic [CW-1:0] count,
    output logic          run,
    output logic          busy,
    output logic          tick
);

    // The tick fires when the top bit of the chain rises
    localparam logic [CW-1:0] FIRE_AT = {1'b1, {(CW-1){1'b0}}};
    // Entering WARN one cycle later puts LEAD busy cycles ahead of the tick
    localparam logic [CW-1:0] WARN_AT = FIRE_AT - CW'(LEAD) - CW'(1);

    chain_state_e state, nxt;

    always_ff @(posedge clk) begin
        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (osc_ctl != OSC_RUN) begin
            nxt = (osc_ctl[2:1] == 2'b11) ? CHAIN_HOLD : CHAIN_STOP;
        end else begin
            unique case (state)
                CHAIN_STOP, CHAIN_HOLD: nxt = CHAIN_COUNT;
                CHAIN_COUNT: if (!set_mode && count == WARN_AT) nxt = CHAIN_WARN;
                CHAIN_WARN:  if (set_mode || count == FIRE_AT)  nxt = CHAIN_COUNT;
                default:     nxt = CHAIN_STOP;
            endcase
        end
    end

    always_comb begin
        run  = (state == CHAIN_COUNT) || (state == CHAIN_WARN);
        busy = (state == CHAIN_WARN) && !set_mode;
        tick = (state == CHAIN_WARN) && !set_mode && (count == FIRE_AT);
    end

endmodule

// File: rtl/rtcdiv_tap.sv
module rtcdiv_tap
    import rtcdiv_pkg::*;
#(
    parameter int CW = 15
) (
    input  logic          rst_n,
    input  logic          run,
    input  logic [3:0]    rate_sel,
    input  logic          sq_enable,
    input  logic [CW-1:0] count,
    output logic          sq_wave,
    output logic          rate_edge
);

    logic [TAP_W-1:0] idx;
    logic [CW-1:0]    low_mask;
    logic             lvl;
    logic             active;

    always_comb begin
        idx      = tap_index(rate_sel);
        low_mask = (CW'(1) << idx) - CW'(1);
        lvl      = count[idx];
        active   = run && (rate_sel != 4'd0);
        sq_wave  = rst_n && sq_enable && active && lvl;
        // The tap has just risen when every bit below it is zero
        rate_edge = active && lvl && ((count & low_mask) == '0);
    end

endmodule

// File: rtl/rtc_rate_divider.sv
module rtc_rate_divider #(
    parameter int CHAIN_BITS = 15,
    parameter int UIP_LEAD   = 8
) (
    input  logic       tb_clk,
    input  logic       rst_n,
    input  logic [3:0] rate_sel,
    input  logic [2:0] osc_ctl,
    input  logic       sq_enable,
    input  logic       set_mode,
    output logic       sq_wave,
    output logic       rate_edge,
    output logic       sec_tick,
    output logic       upd_busy
);

    logic [CHAIN_BITS-1:0] count;
    logic                  run;

    rtcdiv_chain #(.CW(CHAIN_BITS)) i_chain (
        .clk   (tb_clk),
        .run   (run),
        .count (count)
    );

    rtcdiv_seq #(.CW(CHAIN_BITS), .LEAD(UIP_LEAD)) i_seq (
        .clk      (tb_clk),
        .osc_ctl  (osc_ctl),
        .set_mode (set_mode),
        .count    (count),
        .run      (run),
        .busy     (upd_busy),
        .tick     (sec_tick)
    );

    rtcdiv_tap #(.CW(CHAIN_BITS)) i_tap (
        .rst_n     (rst_n),
        .run       (run),
        .rate_sel  (rate_sel),
        .sq_enable (sq_enable),
        .count     (count),
        .sq_wave   (sq_wave),
        .rate_edge (rate_edge)
    );

endmodule

// File: rtl/rtcdiv_check.sv
module rtcdiv_check #(
    parameter int LEAD = 8
) (
    input logic       tb_clk,
    input logic       rst_n,
    input logic [3:0] rate_sel,
    input logic [2:0] osc_ctl,
    input logic       sq_enable,
    input logic       set_mode,
    input logic       sq_wave,
    input logic       rate_edge,
    input logic       sec_tick,
    input logic       upd_busy
);

    logic [4:0] busy_run;
    logic [4:0] since_rst;

    always_ff @(posedge tb_clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run  <= '0;
            since_rst <= '0;
        end else begin
            busy_run  <= upd_busy ? ((busy_run == 5'd31) ? busy_run : busy_run + 5'd1) : 5'd0;
            since_rst <= (since_rst == 5'd31) ? since_rst : since_rst + 5'd1;
        end
    end

    // R2
    held_quiet_chk: assert property (@(posedge tb_clk) disable iff (!rst_n)
        (osc_ctl[2:1] == 2'b11) |=> (!sq_wave && !rate_edge && !sec_tick && !upd_busy));

    // R3
    tick_single_chk: assert property (@(posedge tb_clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

    // R6
    edge_single_chk: assert property (@(posedge tb_clk) disable iff (!rst_n)
        rate_edge |=> !rate_edge);

    // R5
    sq_rise_edge_chk: assert property (@(posedge tb_clk) disable iff (!rst_n)
        (sq_enable && $past(sq_enable) && $past(rst_n) && $stable(rate_sel) && $rose(sq_wave))
        |-> rate_edge);

    // R7
    busy_lead_chk: assert property (@(posedge tb_clk) disable iff (!rst_n)
        (sec_tick && since_rst >= 5'(LEAD)) |-> (busy_run >= 5'(LEAD)));

    // R8
    set_quiet_chk: assert property (@(posedge tb_clk) disable iff (!rst_n)
        set_mode |-> (!sec_tick && !upd_busy));

endmodule

bind rtc_rate_divider rtcdiv_check #(.LEAD(UIP_LEAD)) i_rtcdiv_check (
    .tb_clk    (tb_clk),
    .rst_n     (rst_n),
    .rate_sel  (rate_sel),
    .osc_ctl   (osc_ctl),
    .sq_enable (sq_enable),
    .set_mode  (set_mode),
    .sq_wave   (sq_wave),
    .rate_edge (rate_edge),
    .sec_tick  (sec_tick),
    .upd_busy  (upd_busy)
);

// File: tb/test_rtc_rate_divider.sv
module test_rtc_rate_divider;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] rate_sel;
    logic [2:0] osc_ctl;
    logic       sq_enable;
    logic       set_mode;
    logic       sq_wave;
    logic       rate_edge;
    logic       sec_tick;
    logic       upd_busy;

    int checks = 0;
    int fails  = 0;
    int k      = 0;
    bit done   = 1'b0;

    // First rising tap edge (half period) per rate code; 0 means disabled (R4)
    localparam int FIRST_EDGE [16] = '{0, 64, 128, 2, 4, 8, 16, 32, 64, 128,
                                       256, 512, 1024, 2048, 4096, 8192};
    localparam bit SQE_TBL [16] = '{1, 1, 0, 1, 0, 1, 0, 1, 0, 1, 0, 1, 0, 1, 0, 1};
    localparam logic [2:0] QUIET_CODES [7] = '{3'b110, 3'b111, 3'b000, 3'b001,
                                               3'b011, 3'b100, 3'b101};

    always #10 clk = ~clk;

    rtc_rate_divider i_rtc_rate_divider (
        .tb_clk    (clk),
        .rst_n     (rst_n),
        .rate_sel  (rate_sel),
        .osc_ctl   (osc_ctl),
        .sq_enable (sq_enable),
        .set_mode  (set_mode),
        .sq_wave   (sq_wave),
        .rate_edge (rate_edge),
        .sec_tick  (sec_tick),
        .upd_busy  (upd_busy)
    );

    task automatic step();
        @(negedge clk);
        k++;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int e1, e2, nedge, badsq, lim, noisy;
        int badbusy, badtick, badrst, ntick, t1, t2, setedges;
        bit expsq, expb, expt, inwin;

        rst_n = 1'b0; osc_ctl = 3'b000; rate_sel = 4'd0; sq_enable = 1'b0; set_mode = 1'b0;
        step(); step(); step();
        // R2 R5: outputs quiet in reset with the chain stopped
        check(!sq_wave && !rate_edge && !sec_tick && !upd_busy, "R2 R5 reset outputs",
              {sq_wave, rate_edge, sec_tick, upd_busy}, 0);
        rst_n = 1'b1;
        step();

        // Table walk: every rate code (R1 R4 R5 R6)
        for (int r = 0; r < 16; r++) begin
            osc_ctl = 3'b000; step(); step();
            rate_sel = 4'(r); sq_enable = SQE_TBL[r]; osc_ctl = 3'b010; k = -1;
            e1 = -1; e2 = -1; nedge = 0; badsq = 0;
            lim = (FIRST_EDGE[r] == 0) ? 600 : 3 * FIRST_EDGE[r] + 1;
            while (k < lim) begin
                step();
                if (rate_edge) begin
                    nedge++;
                    if (e1 < 0) e1 = k;
                    else if (e2 < 0) e2 = k;
                end
                if (FIRST_EDGE[r] != 0)
                    expsq = SQE_TBL[r] && (((k / FIRST_EDGE[r]) % 2) == 1);
                else
                    expsq = 1'b0;
                if (sq_wave !== expsq) badsq++;
            end
            if (FIRST_EDGE[r] == 0) begin
                check(nedge == 0, "R4 R6 code 0 gives no strobes", nedge, 0);
            end else begin
                check(e1 == FIRST_EDGE[r], $sformatf("R1 R4 first edge code %0d", r), e1, FIRST_EDGE[r]);
                check(e2 - e1 == 2 * FIRST_EDGE[r], $sformatf("R4 R6 edge spacing code %0d", r),
                      e2 - e1, 2 * FIRST_EDGE[r]);
                check(nedge == 2, $sformatf("R6 edge count code %0d", r), nedge, 2);
            end
            check(badsq == 0, $sformatf("R5 sq_wave tracking code %0d", r), badsq, 0);
        end

        // Non-running codes quieten everything (R2)
        rate_sel = 4'd3; sq_enable = 1'b1;
        for (int c = 0; c < 7; c++) begin
            osc_ctl = 3'b010;
            repeat (10) step();
            osc_ctl = QUIET_CODES[c];
            noisy = 0;
            repeat (60) begin
                step();
                if (sq_wave || rate_edge || sec_tick || upd_busy) noisy++;
            end
            check(noisy == 0, $sformatf("R2 quiet on code %0d", QUIET_CODES[c]), noisy, 0);
        end
        // R1: restart from zero after a stop, code 3 first edge at cycle 2
        osc_ctl = 3'b010; k = -1; e1 = -1;
        while (k < 10) begin
            step();
            if (rate_edge && e1 < 0) e1 = k;
        end
        check(e1 == 2, "R1 restart from zero", e1, 2);

        // Long run: ticks, busy window, reset pulse, hold-off (R3 R7 R8 R9)
        osc_ctl = 3'b000; step(); step();
        rate_sel = 4'd6; sq_enable = 1'b1; set_mode = 1'b0; osc_ctl = 3'b010; k = -1;
        badbusy = 0; badtick = 0; badrst = 0; ntick = 0; t1 = -1; t2 = -1; setedges = 0;
        while (k < 81930) begin
            step();
            inwin = (k >= 16376) && (((k - 16376) % 32768) <= 8);
            expb  = inwin && !set_mode;
            expt  = (k >= 16384) && (((k - 16384) % 32768) == 0) && !set_mode;
            if (upd_busy !== expb) badbusy++;
            if (sec_tick !== expt) badtick++;
            if (sec_tick) begin
                ntick++;
                if (t1 < 0) t1 = k;
                else if (t2 < 0) t2 = k;
            end
            if (k >= 1009 && k <= 1012 && sq_wave) badrst++;
            if (set_mode && rate_edge) setedges++;
            if (k == 1008) rst_n = 1'b0;
            if (k == 1012) rst_n = 1'b1;
            if (k == 70000) set_mode = 1'b1;
        end
        check(badrst == 0, "R5 sq_wave low in reset", badrst, 0);
        check(t1 == 16384, "R3 R9 first tick", t1, 16384);
        check(t2 == 49152, "R3 second tick", t2, 49152);
        check(ntick == 2, "R3 R8 tick count", ntick, 2);
        check(badtick == 0, "R3 tick cycle mismatches", badtick, 0);
        check(badbusy == 0, "R7 R8 R9 busy window mismatches", badbusy, 0);
        check(setedges > 0, "R8 strobes continue under hold-off", setedges, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule